// File: doc/BRIEF.md
# JTAG Erase Sequencer

This block is a JTAG master that clears an attached in-system programmable device. One start strobe makes it drive TCK, TMS and TDI through a fixed program. It first resets the target's TAP controller and loads the enable instruction. If the caller asks for it, it then runs an extra keyed erase step. After that it runs the bulk erase step and a final verify shift. At the end it reports whether the device reads back as erased.

Each erase step has two parts: an 8-bit instruction load, then an 18-bit data shift. After each erase data shift, the block keeps the target in Run-Test/Idle for a programmable number of TCK periods. The verify shift captures TDO on the rising edges of TCK. Only the two low bits of the captured word are checked. The host interface is small: a start strobe, the optional-step flag, and busy, done, pass and fail outputs. TCK is divided down from the system clock and runs only while the block is busy.

Top module: `erase_seq`

## Requirements
- R1: After reset, busy, done, pass, fail, tck, tms and tdi are all low.
- R2: A start pulse seen while idle raises busy on the next cycle and clears done, pass and fail. The target TAP is first reset with five consecutive TCK rises at TMS high, then moved to Run-Test/Idle.
- R3: Every instruction load goes Run-Test/Idle, Select-DR, Select-IR, Capture-IR, then eight Shift-IR bits sent LSB first with TMS high on the last bit, then Update-IR and back to Run-Test/Idle. The first instruction loaded is 8'hE8.
- R4: When opt_erase is high at the accepted start, the enable load is followed by instruction 8'hEC and then the 18-bit data word 18'h2A957, which is 16'hAA55 shifted left by two with both low bits set. When opt_erase is low, this step is skipped.
- R5: The bulk step loads instruction 8'hED and then shifts the 18-bit word 18'h3FFFF. Data shifts pass through Select-DR, Capture-DR and Shift-DR, send LSB first, and return through Update-DR.
- R6: After each erase data shift, exactly WAIT_TCK TCK rising edges occur in Run-Test/Idle with TMS low before the next operation starts.
- R7: The verify step shifts 18'h00001 as a data word with no new instruction. TDO is captured on each shift rise, LSB first. The result is pass when (capture & 18'h00003) == 18'h00001, and fail otherwise.
- R8: Done rises with busy falling, together with exactly one of pass or fail. Done, pass and fail hold until the next accepted start. Pass and fail are never high together and never high without done.
- R9: A start pulse while busy is ignored: no second TAP reset occurs and the running sequence does not change. opt_erase is read only at the accepted start.
- R10: One TCK period is 2*DIV system clocks. TCK is low whenever the block is idle. TMS and TDI change only while TCK is low.
- R11: When done rises, the target TAP is in Run-Test/Idle and TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a sequence when the block is idle |
| opt_erase | input | 1 | Includes the keyed erase step; read at the accepted start |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until the next start |
| pass | output | 1 | Verify matched; valid with done |
| fail | output | 1 | Verify mismatched; valid with done |

## Verification
Completion of one sequence and acceptance of the next start can fall in the same cycle. To provoke this, the bench holds start high across the end of a run. Because the block is no longer busy, the first edge after done rises accepts the held start. The bench then expects done to stay high for exactly one sampled cycle, busy to return at once, and a second TAP reset to appear only after that. Done must never coincide with busy, and the pass/fail result of the previous run must not be carried into the new run.

// File: rtl/erase_pkg.sv
package erase_pkg;

   // kind of one TAP operation run by the operation engine
   typedef enum logic [1:0] {
      OP_RESET,
      OP_IR,
      OP_DR,
      OP_WAIT
   } op_kind_e;

   // sequencer phases, in program order
   typedef enum logic [3:0] {
      PH_IDLE,
      PH_TLR,
      PH_ENABLE,
      PH_ERA_IR,
      PH_ERA_DR,
      PH_ERA_WAIT,
      PH_BULK_IR,
      PH_BULK_DR,
      PH_BULK_WAIT,
      PH_VFY_DR
   } phase_e;

   localparam int RESET_ONES = 5;  // TMS-high rises that force Test-Logic-Reset
   localparam int IR_PRE     = 4;  // rises from Run-Test/Idle into Shift-IR
   localparam int DR_PRE     = 3;  // rises from Run-Test/Idle into Shift-DR
   localparam int POST       = 2;  // Exit1 -> Update -> Run-Test/Idle

endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tck,
   output logic rise,
   output logic fall
);

   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic tick;

   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || cnt == CW'(DIV - 1))
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tck <= 1'b0;
      else if (!run)
         tck <= 1'b0;
      else if (tick)
         tck <= ~tck;
   end

   assign rise = tick && !tck;
   assign fall = tick && tck;

endmodule

// File: rtl/jtag_op_engine.sv
module jtag_op_engine
   import erase_pkg::*;
#(
   parameter int IR_W     = 8,
   parameter int DR_W     = 18,
   parameter int WAIT_TCK = 400000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  op_kind_e        kind,
   input  logic [IR_W-1:0] ir_val,
   input  logic [DR_W-1:0] dr_val,
   input  logic            rise,
   input  logic            fall,
   input  logic            tdo,
   output logic            tms,
   output logic            tdi,
   output logic            last_step,
   output logic [DR_W-1:0] cap
);

   localparam int IR_LEN = IR_PRE + IR_W + POST;
   localparam int DR_LEN = DR_PRE + DR_W + POST;
   localparam int RS_LEN = RESET_ONES + 1;
   localparam int LEN_A  = (IR_LEN > DR_LEN) ? IR_LEN : DR_LEN;
   localparam int LEN_B  = (LEN_A > RS_LEN) ? LEN_A : RS_LEN;
   localparam int MAXLEN = (LEN_B > WAIT_TCK) ? LEN_B : WAIT_TCK;
   localparam int CW     = $clog2(MAXLEN + 1);
   localparam int IW     = $clog2(IR_W);
   localparam int DW     = $clog2(DR_W);

   localparam logic [CW-1:0] C_RS_ONES = CW'(RESET_ONES);
   localparam logic [CW-1:0] C_RS_END  = CW'(RS_LEN - 1);
   localparam logic [CW-1:0] C_IR_B0   = CW'(IR_PRE);
   localparam logic [CW-1:0] C_IR_BL   = CW'(IR_PRE + IR_W - 1);
   localparam logic [CW-1:0] C_IR_UP   = CW'(IR_PRE + IR_W);
   localparam logic [CW-1:0] C_IR_END  = CW'(IR_LEN - 1);
   localparam logic [CW-1:0] C_DR_B0   = CW'(DR_PRE);
   localparam logic [CW-1:0] C_DR_BL   = CW'(DR_PRE + DR_W - 1);
   localparam logic [CW-1:0] C_DR_UP   = CW'(DR_PRE + DR_W);
   localparam logic [CW-1:0] C_DR_END  = CW'(DR_LEN - 1);
   localparam logic [CW-1:0] C_WT_END  = CW'(WAIT_TCK - 1);

   op_kind_e        kind_q;
   logic [IR_W-1:0] ir_q;
   logic [DR_W-1:0] dr_q;
   logic [CW-1:0]   idx;
   logic [CW-1:0]   end_idx;
   logic [IW-1:0]   ir_pos;
   logic [DW-1:0]   dr_pos;
   logic            in_bits;

   // step index -> TMS/TDI; steps change on falling TCK only
   always_comb begin
      tms     = 1'b0;
      tdi     = 1'b0;
      in_bits = 1'b0;
      end_idx = C_WT_END;
      ir_pos  = IW'(idx - C_IR_B0);
      dr_pos  = DW'(idx - C_DR_B0);
      case (kind_q)
         OP_RESET: begin
            end_idx = C_RS_END;
            tms     = (idx < C_RS_ONES);
         end
         OP_IR: begin
            end_idx = C_IR_END;
            if (idx < C_IR_B0) begin
               tms = (idx < CW'(2));
            end else if (idx <= C_IR_BL) begin
               in_bits = 1'b1;
               tdi     = ir_q[ir_pos];
               tms     = (idx == C_IR_BL);
            end else begin
               tms = (idx == C_IR_UP);
            end
         end
         OP_DR: begin
            end_idx = C_DR_END;
            if (idx < C_DR_B0) begin
               tms = (idx == '0);
            end else if (idx <= C_DR_BL) begin
               in_bits = 1'b1;
               tdi     = dr_q[dr_pos];
               tms     = (idx == C_DR_BL);
            end else begin
               tms = (idx == C_DR_UP);
            end
         end
         default: end_idx = C_WT_END;
      endcase
   end

   assign last_step = (idx == end_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= OP_WAIT;
         ir_q   <= '0;
         dr_q   <= '0;
         idx    <= '0;
         cap    <= '0;
      end else begin
         if (load) begin
            kind_q <= kind;
            ir_q   <= ir_val;
            dr_q   <= dr_val;
            idx    <= '0;
         end else if (fall && !last_step) begin
            idx <= idx + 1'b1;
         end
         if (rise && in_bits && kind_q == OP_DR)
            cap <= {tdo, cap[DR_W-1:1]};
      end
   end

endmodule

// File: rtl/erase_seq.sv
module erase_seq
   import erase_pkg::*;
#(
   parameter int              DIV        = 4,
   parameter int              WAIT_TCK   = 400000,
   parameter int              IR_W       = 8,
   parameter int              DR_W       = 18,
   parameter logic [IR_W-1:0] OPC_ENABLE = 8'hE8,
   parameter logic [IR_W-1:0] OPC_ERASE  = 8'hEC,
   parameter logic [IR_W-1:0] OPC_BULK   = 8'hED,
   parameter logic [15:0]     ERASE_KEY  = 16'hAA55,
   parameter logic [DR_W-1:0] VFY_WORD   = 18'h00001,
   parameter logic [DR_W-1:0] VFY_MASK   = 18'h00003,
   parameter logic [DR_W-1:0] VFY_EXPECT = 18'h00001
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic opt_erase,
   input  logic tdo,
   output logic tck,
   output logic tms,
   output logic tdi,
   output logic busy,
   output logic done,
   output logic pass,
   output logic fail
);

   localparam logic [DR_W-1:0] ERASE_WORD = DR_W'({ERASE_KEY, 2'b11});
   localparam logic [DR_W-1:0] ALL_ONES   = '1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("erase_seq: DIV must be at least 1");
      end
      if (WAIT_TCK < 1) begin : g_bad_wait
         $error("erase_seq: WAIT_TCK must be at least 1");
      end
      if (IR_W < 2) begin : g_bad_ir
         $error("erase_seq: IR_W must be at least 2");
      end
      if (DR_W < 18) begin : g_bad_dr
         $error("erase_seq: DR_W must hold the keyed erase word");
      end
   endgenerate

   phase_e          phase, ph_next, ld_phase;
   op_kind_e        ld_kind;
   logic [IR_W-1:0] ld_ir;
   logic [DR_W-1:0] ld_dr;
   logic [DR_W-1:0] cap;
   logic            opt_q;
   logic            rise, fall, last_step, eng_tms, eng_tdi;
   logic            accept, op_end, load, match;

   jtag_tck_div #(.DIV(DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tck  (tck),
      .rise (rise),
      .fall (fall)
   );

   jtag_op_engine #(.IR_W(IR_W), .DR_W(DR_W), .WAIT_TCK(WAIT_TCK)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .kind     (ld_kind),
      .ir_val   (ld_ir),
      .dr_val   (ld_dr),
      .rise     (rise),
      .fall     (fall),
      .tdo      (tdo),
      .tms      (eng_tms),
      .tdi      (eng_tdi),
      .last_step(last_step),
      .cap      (cap)
   );

   assign accept = start && !busy;
   assign op_end = busy && fall && last_step;
   assign match  = ((cap & VFY_MASK) == VFY_EXPECT);

   always_comb begin
      case (phase)
         PH_TLR:       ph_next = PH_ENABLE;
         PH_ENABLE:    ph_next = opt_q ? PH_ERA_IR : PH_BULK_IR;
         PH_ERA_IR:    ph_next = PH_ERA_DR;
         PH_ERA_DR:    ph_next = PH_ERA_WAIT;
         PH_ERA_WAIT:  ph_next = PH_BULK_IR;
         PH_BULK_IR:   ph_next = PH_BULK_DR;
         PH_BULK_DR:   ph_next = PH_BULK_WAIT;
         PH_BULK_WAIT: ph_next = PH_VFY_DR;
         default:      ph_next = PH_IDLE;
      endcase
   end

   assign ld_phase = accept ? PH_TLR : ph_next;
   assign load     = accept || (op_end && ph_next != PH_IDLE);

   always_comb begin
      ld_kind = OP_WAIT;
      ld_ir   = '0;
      ld_dr   = '0;
      case (ld_phase)
         PH_TLR:     ld_kind = OP_RESET;
         PH_ENABLE:  begin ld_kind = OP_IR; ld_ir = OPC_ENABLE; end
         PH_ERA_IR:  begin ld_kind = OP_IR; ld_ir = OPC_ERASE;  end
         PH_BULK_IR: begin ld_kind = OP_IR; ld_ir = OPC_BULK;   end
         PH_ERA_DR:  begin ld_kind = OP_DR; ld_dr = ERASE_WORD; end
         PH_BULK_DR: begin ld_kind = OP_DR; ld_dr = ALL_ONES;   end
         PH_VFY_DR:  begin ld_kind = OP_DR; ld_dr = VFY_WORD;   end
         default:    ld_kind = OP_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         opt_q <= 1'b0;
         busy  <= 1'b0;
         done  <= 1'b0;
         pass  <= 1'b0;
         fail  <= 1'b0;
      end else if (accept) begin
         phase <= PH_TLR;
         opt_q <= opt_erase;
         busy  <= 1'b1;
         done  <= 1'b0;
         pass  <= 1'b0;
         fail  <= 1'b0;
      end else if (op_end) begin
         phase <= ph_next;
         if (ph_next == PH_IDLE) begin
            busy <= 1'b0;
            done <= 1'b1;
            pass <= match;
            fail <= !match;
         end
      end
   end

   assign tms = busy && eng_tms;
   assign tdi = busy && eng_tdi;

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic tck,
   input logic tms,
   input logic tdi,
   input logic busy,
   input logic done,
   input logic pass,
   input logic fail
);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail));

   p_flag_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || fail) |-> done);

   p_busy_not_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done && !pass && !fail));

   p_idle_tck_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tck);

   p_tms_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> $stable(tms));

   p_tdi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> $stable(tdi));

endmodule

bind erase_seq erase_seq_chk u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .tck  (tck),
   .tms  (tms),
   .tdi  (tdi),
   .busy (busy),
   .done (done),
   .pass (pass),
   .fail (fail)
);

// File: tb/erase_seq_tb.sv
module erase_seq_tb;

   localparam int DIV  = 2;
   localparam int WAIT = 12;
   localparam int NV   = 7;
   // {opt_erase, TDO capture word, expected pass}
   localparam logic [19:0] VEC [NV] = '{
      {1'b1, 18'h00001, 1'b1},
      {1'b0, 18'h00001, 1'b1},
      {1'b1, 18'h00003, 1'b0},
      {1'b0, 18'h3FFFD, 1'b1},
      {1'b0, 18'h00002, 1'b0},
      {1'b1, 18'h3FFFC, 1'b0},
      {1'b0, 18'h00000, 1'b0}
   };

   typedef enum logic [3:0] {
      T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PADR, T_EX2DR,
      T_UPDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAIR, T_EX2IR, T_UPIR
   } tap_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic opt_erase = 1'b0;
   logic tdo = 1'b0;
   logic tck, tms, tdi, busy, done, pass, fail;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // target model state
   tap_e        st = T_TLR;
   logic [7:0]  ir_sh = '0;
   logic [17:0] dr_sh = '0;
   logic [17:0] out_sh = '0;
   logic [17:0] status_val = '0;
   int ones = 0, resets = 0, run = 0, last_run = 0, n_ops = 0;
   int rise_prev = 0, rise_last = 0;
   int          op_kind [8];
   logic [17:0] op_val  [8];
   int          op_run  [8];
   int          ne = 0;
   int          ek [8];
   logic [17:0] ev [8];
   int          er [8];

   always #4 clk = ~clk;

   erase_seq #(.DIV(DIV), .WAIT_TCK(WAIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opt_erase(opt_erase), .tdo(tdo),
      .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done), .pass(pass), .fail(fail)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge tck) begin
      rise_prev = rise_last;
      rise_last = cyc;
      if (tms) begin
         ones = ones + 1;
         if (ones == 5) resets = resets + 1;
      end else begin
         ones = 0;
      end
      if (st == T_RTI) begin
         if (!tms) run = run + 1;
         else begin last_run = run; run = 0; end
      end
      if (st == T_SHIR) ir_sh = {tdi, ir_sh[7:1]};
      if (st == T_SHDR) begin
         dr_sh  = {tdi, dr_sh[17:1]};
         out_sh = out_sh >> 1;
      end
      if (st == T_CAPDR) out_sh = status_val;
      if (tms && (st == T_EX1IR || st == T_EX1DR) && n_ops < 8) begin
         op_kind[n_ops] = (st == T_EX1DR) ? 1 : 0;
         op_val[n_ops]  = (st == T_EX1DR) ? dr_sh : {10'b0, ir_sh};
         op_run[n_ops]  = last_run;
         n_ops = n_ops + 1;
      end
      case (st)
         T_TLR:   st = tms ? T_TLR   : T_RTI;
         T_RTI:   st = tms ? T_SELDR : T_RTI;
         T_SELDR: st = tms ? T_SELIR : T_CAPDR;
         T_CAPDR: st = tms ? T_EX1DR : T_SHDR;
         T_SHDR:  st = tms ? T_EX1DR : T_SHDR;
         T_EX1DR: st = tms ? T_UPDR  : T_PADR;
         T_PADR:  st = tms ? T_EX2DR : T_PADR;
         T_EX2DR: st = tms ? T_UPDR  : T_SHDR;
         T_UPDR:  st = tms ? T_SELDR : T_RTI;
         T_SELIR: st = tms ? T_TLR   : T_CAPIR;
         T_CAPIR: st = tms ? T_EX1IR : T_SHIR;
         T_SHIR:  st = tms ? T_EX1IR : T_SHIR;
         T_EX1IR: st = tms ? T_UPIR  : T_PAIR;
         T_PAIR:  st = tms ? T_EX2IR : T_PAIR;
         T_EX2IR: st = tms ? T_UPIR  : T_SHIR;
         default: st = tms ? T_SELDR : T_RTI;
      endcase
   end

   always @(negedge tck) tdo = (st == T_SHDR) ? out_sh[0] : 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
      end
   endtask

   task automatic clear_model();
      resets = 0; ones = 0; run = 0; last_run = 0; n_ops = 0;
   endtask

   task automatic add_exp(input int k, input logic [17:0] v, input int r);
      ek[ne] = k; ev[ne] = v; er[ne] = r; ne++;
   endtask

   task automatic build_exp(input bit opt);
      ne = 0;
      add_exp(0, 18'h000E8, 0);
      if (opt) begin
         add_exp(0, 18'h000EC, 0);
         add_exp(1, 18'h2A957, 0);
         add_exp(0, 18'h000ED, WAIT);
      end else begin
         add_exp(0, 18'h000ED, 0);
      end
      add_exp(1, 18'h3FFFF, 0);
      add_exp(1, 18'h00001, WAIT);
   endtask

   task automatic wait_done();
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if (done) break;
      end
   endtask

   task automatic pulse_start(input bit opt);
      @(negedge clk);
      opt_erase = opt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   always @(posedge clk) begin
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy, done, pass, fail, tck, tms, tdi} == 7'b0, "R1", "outputs in reset", {busy, done, pass, fail, tck, tms, tdi}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({busy, done, pass, fail, tck} == 5'b0, "R1", "outputs after reset", {busy, done, pass, fail, tck}, 0);

      for (int i = 0; i < NV; i++) begin
         clear_model();
         status_val = VEC[i][18:1];
         build_exp(VEC[i][19]);
         pulse_start(VEC[i][19]);
         chk(busy == 1'b1 && done == 1'b0, "R2", "busy after start", busy, 1);
         wait_done();
         chk(done == 1'b1 && busy == 1'b0, "R8", "done raised", done, 1);
         chk(pass == VEC[i][0], "R7", "pass result", pass, VEC[i][0]);
         chk(fail == !VEC[i][0], "R7", "fail result", fail, !VEC[i][0]);
         chk(resets == 1, "R2", "TAP reset count", resets, 1);
         chk(n_ops == ne, VEC[i][19] ? "R4" : "R5", "operation count", n_ops, ne);
         for (int k = 0; k < ne && k < n_ops; k++) begin
            chk(op_kind[k] == ek[k] && op_val[k] == ev[k], k == 0 ? "R3" : "R5",
                "operation value", op_val[k], ev[k]);
            chk(op_run[k] == er[k], "R6", "idle rises before operation", op_run[k], er[k]);
         end
         chk(st == T_RTI && tck == 1'b0, "R11", "target state at done", st, T_RTI);
         chk(rise_last - rise_prev == 2 * DIV, "R10", "tck period", rise_last - rise_prev, 2 * DIV);
      end

      // R9: start while busy and opt_erase change are ignored
      clear_model();
      status_val = 18'h00001;
      build_exp(1'b0);
      pulse_start(1'b0);
      repeat (100) @(negedge clk);
      opt_erase = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      chk(resets == 1, "R9", "no restart while busy", resets, 1);
      chk(n_ops == ne, "R9", "optional step not added", n_ops, ne);
      chk(pass == 1'b1, "R9", "run result", pass, 1);

      // R8: done held while idle
      repeat (20) @(negedge clk);
      chk(done && pass && !fail && !busy, "R8", "flags held", {done, pass, fail, busy}, 4'b1100);
      chk(tck == 1'b0, "R10", "tck idle low", tck, 0);

      // completion meets a held start in the same cycle
      clear_model();
      status_val = 18'h00002;
      opt_erase = 1'b0;
      start = 1'b1;
      @(negedge clk);
      chk(busy && !done && !pass, "R2", "held start accepted over done", {busy, done, pass}, 3'b100);
      wait_done();
      begin
         int n = 0;
         while (done && n < 10) begin
            n++;
            @(negedge clk);
         end
         chk(n == 1, "R8", "done cycles with start held", n, 1);
      end
      chk(busy == 1'b1 && fail == 1'b0, "R9", "restart after completion", {busy, fail}, 2'b10);
      start = 1'b0;
      status_val = 18'h00001;
      wait_done();
      chk(resets == 2, "R2", "second TAP reset only after done", resets, 2);
      chk(pass == 1'b1, "R7", "second run result", pass, 1);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule